// File: doc/BRIEF.md
# Sensor Error Generator with Signed Bounds Window

This block turns raw readings from an on-die performance sensor into a signed percentage error against a target. Software programs a reciprocal of the target reading as an 8-bit scale with a 4-bit right-shift gain. One such pair exists for the N-type sensor and one for the P-type sensor, and a select input chooses which pair applies to the current reading. Each accepted reading is multiplied by the selected scale and shifted right by the gain. The value 256 stands for 100 %. The block subtracts 256 from the shifted product and saturates the result to a signed 8-bit error.

The block also keeps a smoothed error: an exponential moving average whose step size is set by a 3-bit shift weight. Every new error is compared against a programmable signed window. An error outside that window produces a one-cycle bounds event, which a voltage controller or an interrupt stage further downstream can consume. When the generator enable is low, all results and flags are held cleared and readings are ignored.

Top module: `sensor_error_gen`

## Requirements
- R1: A reading is accepted on a clock edge where `gen_enable` and `sample_valid` are both 1. On that edge `err_out` takes the value sat8(((sample × scale) >> gain) − 256), where the product is unsigned and sat8 clamps to the range −128..+127 in two's complement. The new value is visible in the cycle after the strobe.
- R2: `pol_sel` = 0 applies the `n_scale`/`n_gain` pair and `pol_sel` = 1 applies the `p_scale`/`p_gain` pair. The unselected pair has no effect on any output.
- R3: A difference above +127 gives `err_out` = 0x7F, and a difference below −128 gives `err_out` = 0x80.
- R4: The first reading accepted after reset or after enabling seeds `avg_err_out` with that reading's error. Each later reading updates it as avg + ((err − avg) >>> `avg_weight`), computed signed with arithmetic shift (rounding toward minus infinity).
- R5: `bounds_pulse` is 1 for exactly the one cycle that follows an accepted reading whose error is signed-greater than `err_hi_limit` or signed-less than `err_lo_limit`. An error equal to either limit gives no pulse.
- R6: After reset, `err_out`, `avg_err_out`, `err_valid`, `avg_valid` and `bounds_pulse` are all 0.
- R7: While `gen_enable` is 0, all five outputs are cleared on the next edge, and strobed readings change nothing.
- R8: Between accepted readings, `err_out` and `avg_err_out` hold their values and `bounds_pulse` stays 0.
- R9: `err_valid` becomes 1 with the first accepted reading. `avg_valid` becomes 1 with the second accepted reading, meaning at least one averaging step has happened. Both stay at 1 until reset or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_enable | input | 1 | Generator enable; 0 clears and idles the block |
| sample_valid | input | 1 | Strobe marking `sample` as a new reading |
| sample | input | 16 | Unsigned sensor reading |
| pol_sel | input | 1 | 0 selects the N reciprocal pair, 1 selects the P pair |
| n_scale | input | 8 | Reciprocal scale for N readings |
| n_gain | input | 4 | Right-shift gain for N readings |
| p_scale | input | 8 | Reciprocal scale for P readings |
| p_gain | input | 4 | Right-shift gain for P readings |
| avg_weight | input | 3 | Averaging shift weight |
| err_hi_limit | input | 8 | Signed upper error limit (0x7F when idle) |
| err_lo_limit | input | 8 | Signed lower error limit (0x80 when idle) |
| err_out | output | 8 | Signed percentage error of the last reading |
| avg_err_out | output | 8 | Signed averaged error |
| err_valid | output | 1 | `err_out` holds a result |
| avg_valid | output | 1 | `avg_err_out` holds at least one averaging step |
| bounds_pulse | output | 1 | One-cycle pulse for an out-of-window error |

## Verification
The bench sweeps every gain value across a spread of scales and readings, on both polarities. In doing so it drives the shifted product through zero, through exactly 256, and far past the saturation points. A design that wrapped instead of clamping, or that used the unselected pair, would show wrong errors there. A signed window of ±10 is then walked one step at a time across its edges. A design that compared unsigned, or that treated the limits as exclusive, would pulse at ±10 or miss ±11. The bench also checks the averaging seed, arithmetic rounding of negative steps at each weight, the hold between strobes, and the clear on disable. A design that averaged from zero, shifted logically, or kept stale flags would diverge from the bench's running model.

// File: rtl/sensor_err_pkg.sv
// Shared widths and the reciprocal record used by the error generator.
package sensor_err_pkg;
    localparam int SCALE_W = 8;
    localparam int GAIN_W  = 4;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [GAIN_W-1:0]  gain;
    } recip_t;
endpackage

// File: rtl/sensor_err_calc.sv
// Forms the saturated signed error of one reading against a reciprocal.
// Assumes the reference level REF_ONE represents 100 % after the shift.
module sensor_err_calc
    import sensor_err_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ERR_W    = 8,
    parameter int REF_ONE  = 256
) (
    input  logic [SAMPLE_W-1:0]     sample,
    input  recip_t                  recip,
    output logic signed [ERR_W-1:0] err
);
    localparam int PROD_W = SAMPLE_W + SCALE_W;
    localparam int DIFF_W = PROD_W + 2;
    localparam logic signed [DIFF_W-1:0] ERR_MAX = DIFF_W'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] ERR_MIN = -DIFF_W'(1 << (ERR_W - 1));
    localparam logic signed [DIFF_W-1:0] REF_V   = DIFF_W'(REF_ONE);

    logic [PROD_W-1:0]        prod_full;
    logic [PROD_W-1:0]        prod_shift;
    logic signed [DIFF_W-1:0] diff;

    // Scale, shift by gain, subtract the reference and clamp.
    always_comb begin
        prod_full  = PROD_W'(sample) * PROD_W'(recip.scale);
        prod_shift = prod_full >> recip.gain;
        diff       = $signed({2'b00, prod_shift}) - REF_V;
        if (diff > ERR_MAX)
            err = ERR_MAX[ERR_W-1:0];
        else if (diff < ERR_MIN)
            err = ERR_MIN[ERR_W-1:0];
        else
            err = diff[ERR_W-1:0];
    end
endmodule

// File: rtl/sensor_err_avg.sv
// Computes the next value of the exponential moving average of the error.
// Assumes the caller seeds the average separately on the first reading.
module sensor_err_avg #(
    parameter int ERR_W    = 8,
    parameter int WEIGHT_W = 3
) (
    input  logic signed [ERR_W-1:0] err_in,
    input  logic signed [ERR_W-1:0] avg_in,
    input  logic [WEIGHT_W-1:0]     weight,
    output logic signed [ERR_W-1:0] avg_next
);
    logic signed [ERR_W:0] delta;
    logic signed [ERR_W:0] step;
    logic signed [ERR_W:0] sum;

    // Move the average toward the error by a shifted fraction of the gap.
    always_comb begin
        delta    = {err_in[ERR_W-1], err_in} - {avg_in[ERR_W-1], avg_in};
        step     = delta >>> weight;
        sum      = {avg_in[ERR_W-1], avg_in} + step;
        avg_next = sum[ERR_W-1:0];
    end
endmodule

// File: rtl/sensor_err_window.sv
// Flags an error lying outside an inclusive signed limit window.
// Assumes both limits are two's complement; lo above hi flags everything.
module sensor_err_window #(
    parameter int ERR_W = 8
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ERR_W-1:0] lim_hi,
    input  logic signed [ERR_W-1:0] lim_lo,
    output logic                    outside
);
    // Signed comparison against both edges of the window.
    always_comb begin
        outside = (err > lim_hi) || (err < lim_lo);
    end
endmodule

// File: rtl/sensor_error_gen.sv
// Top of the sensor error generator: selects the reciprocal for the
// reading's polarity, registers error, average, flags and bounds pulse.
// Assumes sample_valid is a single-cycle strobe per reading.
module sensor_error_gen
    import sensor_err_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ERR_W    = 8,
    parameter int WEIGHT_W = 3,
    parameter int REF_ONE  = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_enable,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                pol_sel,
    input  logic [SCALE_W-1:0]  n_scale,
    input  logic [GAIN_W-1:0]   n_gain,
    input  logic [SCALE_W-1:0]  p_scale,
    input  logic [GAIN_W-1:0]   p_gain,
    input  logic [WEIGHT_W-1:0] avg_weight,
    input  logic [ERR_W-1:0]    err_hi_limit,
    input  logic [ERR_W-1:0]    err_lo_limit,
    output logic [ERR_W-1:0]    err_out,
    output logic [ERR_W-1:0]    avg_err_out,
    output logic                err_valid,
    output logic                avg_valid,
    output logic                bounds_pulse
);
    localparam int NUM_POL = 2;

    recip_t                  pair_tab [NUM_POL];
    recip_t                  recip_sel;
    logic signed [ERR_W-1:0] err_c;
    logic signed [ERR_W-1:0] avg_c;
    logic                    outside_c;
    logic signed [ERR_W-1:0] err_q;
    logic signed [ERR_W-1:0] avg_q;
    logic                    take;

    // Gather the per-polarity reciprocal pairs into a table.
    always_comb begin
        pair_tab[0] = '{scale: n_scale, gain: n_gain};
        pair_tab[1] = '{scale: p_scale, gain: p_gain};
    end

    // Pick the pair belonging to the current reading.
    always_comb begin
        recip_sel = pair_tab[pol_sel];
        take      = gen_enable && sample_valid;
    end

    sensor_err_calc #(
        .SAMPLE_W(SAMPLE_W),
        .ERR_W   (ERR_W),
        .REF_ONE (REF_ONE)
    ) u_calc (
        .sample(sample),
        .recip (recip_sel),
        .err   (err_c)
    );

    sensor_err_avg #(
        .ERR_W   (ERR_W),
        .WEIGHT_W(WEIGHT_W)
    ) u_avg (
        .err_in  (err_c),
        .avg_in  (avg_q),
        .weight  (avg_weight),
        .avg_next(avg_c)
    );

    sensor_err_window #(
        .ERR_W(ERR_W)
    ) u_win (
        .err    (err_c),
        .lim_hi ($signed(err_hi_limit)),
        .lim_lo ($signed(err_lo_limit)),
        .outside(outside_c)
    );

    // Result registers: cleared by reset or disable, loaded per reading.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_enable) begin
            err_q        <= '0;
            avg_q        <= '0;
            err_valid    <= 1'b0;
            avg_valid    <= 1'b0;
            bounds_pulse <= 1'b0;
        end else if (take) begin
            err_q        <= err_c;
            avg_q        <= err_valid ? avg_c : err_c;
            err_valid    <= 1'b1;
            avg_valid    <= err_valid;
            bounds_pulse <= outside_c;
        end else begin
            bounds_pulse <= 1'b0;
        end
    end

    // Drive the ports from the result registers.
    always_comb begin
        err_out     = err_q;
        avg_err_out = avg_q;
    end
endmodule

// File: rtl/sensor_error_gen_chk.sv
// Property checker for sensor_error_gen, attached by bind.
module sensor_error_gen_chk #(
    parameter int SAMPLE_W = 16,
    parameter int ERR_W    = 8,
    parameter int WEIGHT_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                gen_enable,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] sample,
    input logic [ERR_W-1:0]    err_hi_limit,
    input logic [ERR_W-1:0]    err_lo_limit,
    input logic [ERR_W-1:0]    err_out,
    input logic [ERR_W-1:0]    avg_err_out,
    input logic                err_valid,
    input logic                avg_valid,
    input logic                bounds_pulse
);
    // R7: disable clears every result on the next edge.
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_enable |=> (!err_valid && !avg_valid && !bounds_pulse && err_out == '0 && avg_err_out == '0));

    // R5: a pulse only follows an accepted reading and lies outside the window.
    a_r5_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bounds_pulse |-> $past(gen_enable && sample_valid));

    a_r5_pulse_outside: assert property (@(posedge clk) disable iff (!rst_n)
        bounds_pulse |-> ($signed(err_out) > $signed($past(err_hi_limit)) ||
                          $signed(err_out) < $signed($past(err_lo_limit))));

    // R8: results hold while no reading is accepted.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_enable && !sample_valid) |=> ($stable(err_out) && $stable(avg_err_out) && !bounds_pulse));

    // R9: an accepted reading sets err_valid; avg_valid needs err_valid.
    a_r9_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_enable && sample_valid) |=> err_valid);

    a_r9_avg_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> err_valid);
endmodule

bind sensor_error_gen sensor_error_gen_chk #(
    .SAMPLE_W(SAMPLE_W),
    .ERR_W   (ERR_W),
    .WEIGHT_W(WEIGHT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_enable  (gen_enable),
    .sample_valid(sample_valid),
    .sample      (sample),
    .err_hi_limit(err_hi_limit),
    .err_lo_limit(err_lo_limit),
    .err_out     (err_out),
    .avg_err_out (avg_err_out),
    .err_valid   (err_valid),
    .avg_valid   (avg_valid),
    .bounds_pulse(bounds_pulse)
);

// File: tb/sensor_error_gen_test.sv
module sensor_error_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_enable = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample = '0;
    logic        pol_sel = 1'b0;
    logic [7:0]  n_scale = '0;
    logic [3:0]  n_gain = '0;
    logic [7:0]  p_scale = '0;
    logic [3:0]  p_gain = '0;
    logic [2:0]  avg_weight = '0;
    logic [7:0]  err_hi_limit = 8'h7F;
    logic [7:0]  err_lo_limit = 8'h80;
    logic [7:0]  err_out;
    logic [7:0]  avg_err_out;
    logic        err_valid;
    logic        avg_valid;
    logic        bounds_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m_avg = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    sensor_error_gen uut (.*);

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_err(input int s, input int sc, input int g);
        longint p;
        int d;
        p = (longint'(s) * sc) >> g;
        d = int'(p) - 256;
        if (d > 127) return 127;
        if (d < -128) return -128;
        return d;
    endfunction

    // Apply one reading and check every output in the following cycle.
    task automatic apply(input int s, input bit pol);
        int e, sc, g, hi, lo;
        bit outb;
        @(negedge clk);
        sample = 16'(s);
        pol_sel = pol;
        sample_valid = 1'b1;
        sc = pol ? int'(p_scale) : int'(n_scale);
        g  = pol ? int'(p_gain) : int'(n_gain);
        e = model_err(s, sc, g);
        hi = int'($signed(err_hi_limit));
        lo = int'($signed(err_lo_limit));
        outb = (e > hi) || (e < lo);
        if (m_cnt == 0) m_avg = e;
        else m_avg = m_avg + ((e - m_avg) >>> int'(avg_weight));
        m_cnt++;
        @(negedge clk);
        sample_valid = 1'b0;
        chk(int'($signed(err_out)), e, pol ? "R1/R2/R3 err P" : "R1/R2/R3 err N");
        chk(int'($signed(avg_err_out)), m_avg, "R4 avg");
        chk(int'(err_valid), 1, "R9 err_valid");
        chk(int'(avg_valid), int'(m_cnt > 1), "R9 avg_valid");
        chk(int'(bounds_pulse), int'(outb), "R5 bounds");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int samples [7] = '{0, 1, 255, 256, 1000, 40000, 65535};
        int e_hold, a_hold;
        repeat (4) @(negedge clk);
        // R6: reset state
        chk(int'(err_out), 0, "R6 err");
        chk(int'(avg_err_out), 0, "R6 avg");
        chk(int'(err_valid), 0, "R6 err_valid");
        chk(int'(avg_valid), 0, "R6 avg_valid");
        chk(int'(bounds_pulse), 0, "R6 bounds");
        rst_n = 1'b1;
        gen_enable = 1'b1;

        // R1 R2 R3 R4: sweep gains, scales, readings on both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int g = 0; g < 16; g++) begin
                for (int sc = 0; sc < 256; sc += 15) begin
                    if (pol == 1) begin
                        p_scale = 8'(sc); p_gain = 4'(g);
                        n_scale = 8'(255 - sc); n_gain = 4'(15 - g);
                    end else begin
                        n_scale = 8'(sc); n_gain = 4'(g);
                        p_scale = 8'(255 - sc); p_gain = 4'(15 - g);
                    end
                    avg_weight = 3'(g + sc);
                    foreach (samples[i]) apply(samples[i], bit'(pol));
                end
            end
        end

        // R5: walk a +/-10 window with unity reciprocal
        n_scale = 8'd1; n_gain = 4'd0;
        err_hi_limit = 8'd10;
        err_lo_limit = 8'hF6;
        for (int k = -30; k <= 30; k++) apply(256 + k, 1'b0);

        // R8: hold between readings
        e_hold = int'(err_out);
        a_hold = int'(avg_err_out);
        repeat (3) @(negedge clk);
        chk(int'(err_out), e_hold, "R8 err hold");
        chk(int'(avg_err_out), a_hold, "R8 avg hold");
        chk(int'(bounds_pulse), 0, "R8 no pulse");

        // R7: disable clears and ignores readings
        gen_enable = 1'b0;
        @(negedge clk);
        sample = 16'd100; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        chk(int'(err_out), 0, "R7 err");
        chk(int'(avg_err_out), 0, "R7 avg");
        chk(int'(err_valid), 0, "R7 err_valid");
        chk(int'(avg_valid), 0, "R7 avg_valid");
        chk(int'(bounds_pulse), 0, "R7 bounds");

        // R4 R9: re-enable seeds the average again, negative rounding
        gen_enable = 1'b1;
        m_cnt = 0;
        avg_weight = 3'd2;
        apply(200, 1'b0);
        apply(300, 1'b0);
        apply(250, 1'b0);
        avg_weight = 3'd7;
        apply(130, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule